// File: doc/BRIEF.md
# Field-Arithmetic Byte Substitution Unit

This unit performs the AES byte substitution, and its inverse, on a 32-bit word that is treated as four separate bytes. No constant table is stored. Each substituted byte is computed from arithmetic in GF(2^8) reduced by x^8+x^4+x^3+x+1.

In the forward direction a byte is inverted in the field and then passed through an affine map over GF(2). In the inverse direction the byte first goes through the inverse affine map and then through the same field inverter. Each byte lane therefore needs only one inverter, shared by both directions. The inverter raises its operand to the power 254 with a chain of squarings and multiplications, so 0x00 maps to 0x00 without any special case.

The datapath is combinational. A parameter adds an output register after it. A round datapath instantiates the unit once for each column word and selects the direction per word.

Top module: `sbox_word_unit`

## Requirements
- R1: Each output byte lane k (bits 8k+7..8k) depends only on input byte lane k. Changing one input lane leaves the other output lanes unchanged.
- R2: With `inv_sel`=0 each lane outputs A(x^-1). Here x^-1 is the multiplicative inverse of the input byte in GF(2^8) modulo 0x11B.
- R3: The field inversion maps 0x00 to 0x00. So forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R4: With `inv_sel`=1 each lane outputs (B(y))^-1, where y is the input byte and B is the inverse affine map. For output bit i, B gives y[(i+2)%8] ^ y[(i+5)%8] ^ y[(i+7)%8] ^ bit i of 0x05.
- R5: The forward affine map A sets output bit i to x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ bit i of 0x63.
- R6: Applying the inverse substitution to the result of the forward substitution returns the original byte, for all 256 byte values.
- R7: With OUT_REG=1 (the default), `word_out` shows the result for the inputs present at the previous rising clock edge. The register clears to 0 while `rst_n` is low. With OUT_REG=0, `word_out` is combinational.
- R8: The direction can change on every word. Each result follows the `inv_sel` value sampled together with its own input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| inv_sel | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| word_in | input | 32 | Four input bytes, lane 0 in bits 7..0 |
| word_out | output | 32 | Four substituted bytes, same lane order |

## Verification
A fault in the squaring and multiplication chain gives a wrong byte on `word_out` one clock after the offending input. It shows only for the input values that reach the faulty term, so all 256 values are swept in both directions, in every lane. A wrong affine bit or constant breaks the forward-then-inverse round trip for most bytes, and the 0x00 and 0x63 fixed points expose a wrong constant directly. A swapped or shared lane wire shows as a change in a neighbouring output lane during the one-lane sweep, in the same cycle its result appears.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;
  localparam logic [BYTE_W-1:0] REDUCE    = 8'h1b;

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? REDUCE : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_sq(input logic [7:0] a);
    return gf_mul(a, a);
  endfunction

  function automatic logic [7:0] fwd_affine(input logic [7:0] x);
    return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ FWD_CONST;
  endfunction

  function automatic logic [7:0] inv_affine(input logic [7:0] y);
    return rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ INV_CONST;
  endfunction
endpackage

// File: rtl/gf_inverter.sv
module gf_inverter
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] op_in,
  output logic [BYTE_W-1:0] op_inv
);
  localparam int NSQ  = BYTE_W - 1;
  localparam int NMUL = NSQ - 1;

  logic [BYTE_W-1:0] sq [NSQ+1];
  logic [BYTE_W-1:0] pr [NMUL];

  assign sq[0] = op_in;

  for (genvar k = 1; k <= NSQ; k++) begin : g_sq
    assign sq[k] = gf_sq(sq[k-1]);
  end

  assign pr[0] = gf_mul(sq[1], sq[2]);
  for (genvar k = 1; k < NMUL; k++) begin : g_mul
    assign pr[k] = gf_mul(pr[k-1], sq[k+2]);
  end

  assign op_inv = pr[NMUL-1];
endmodule

// File: rtl/sbox_lane.sv
module sbox_lane
  import sbox_pkg::*;
(
  input  logic              inv_sel,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic [BYTE_W-1:0] core_in,
  output logic [BYTE_W-1:0] core_out
);
  assign core_in = inv_sel ? inv_affine(byte_in) : byte_in;

  gf_inverter u_inv (
    .op_in (core_in),
    .op_inv(core_out)
  );

  assign byte_out = inv_sel ? core_out : fwd_affine(core_out);
endmodule

// File: rtl/sbox_word_unit.sv
module sbox_word_unit
  import sbox_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inv_sel,
  input  logic [LANES*BYTE_W-1:0] word_in,
  output logic [LANES*BYTE_W-1:0] word_out
);
  localparam int WORD_W = LANES * BYTE_W;

  logic [WORD_W-1:0] comb_word;
  logic [WORD_W-1:0] inv_in_bus;
  logic [WORD_W-1:0] inv_out_bus;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sbox_lane u_lane (
      .inv_sel (inv_sel),
      .byte_in (word_in[k*BYTE_W +: BYTE_W]),
      .byte_out(comb_word[k*BYTE_W +: BYTE_W]),
      .core_in (inv_in_bus[k*BYTE_W +: BYTE_W]),
      .core_out(inv_out_bus[k*BYTE_W +: BYTE_W])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) word_out <= '0;
      else        word_out <= comb_word;
    end
  end else begin : g_comb
    assign word_out = comb_word;
  end
endmodule

// File: rtl/sbox_word_unit_chk.sv
module sbox_word_unit_chk #(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_sel,
  input logic [LANES*8-1:0] word_in,
  input logic [LANES*8-1:0] word_out,
  input logic [LANES*8-1:0] comb_word,
  input logic [LANES*8-1:0] inv_in_bus,
  input logic [LANES*8-1:0] inv_out_bus
);
  function automatic logic [7:0] c_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] t;
    t = '0;
    for (int i = 0; i < 8; i++) if (b[i]) t = t ^ (15'(a) << i);
    for (int j = 14; j >= 8; j--) if (t[j]) t = t ^ (15'h11b << (j - 8));
    return t[7:0];
  endfunction

  function automatic logic [7:0] c_fwd(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  function automatic logic [7:0] c_inv(input logic [7:0] y);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = y[(i+2)%8] ^ y[(i+5)%8] ^ y[(i+7)%8];
    return r ^ 8'h05;
  endfunction

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R2: inverter output times its input is one
    a_r2_field_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_in_bus[k*8 +: 8] != 8'h00) |-> (c_mul(inv_in_bus[k*8 +: 8], inv_out_bus[k*8 +: 8]) == 8'h01));
    // R3: zero stays zero through the inverter
    a_r3_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_in_bus[k*8 +: 8] == 8'h00) |-> (inv_out_bus[k*8 +: 8] == 8'h00));
    // R4: inverse path feeds the inverter with the inverse affine image
    a_r4_inv_pre_map: assert property (@(posedge clk) disable iff (!rst_n)
      inv_sel |-> (c_fwd(inv_in_bus[k*8 +: 8]) == word_in[k*8 +: 8]));
    // R5: forward result undoes to the inverter output
    a_r5_fwd_post_map: assert property (@(posedge clk) disable iff (!rst_n)
      !inv_sel |-> (c_inv(comb_word[k*8 +: 8]) == inv_out_bus[k*8 +: 8]));
  end

  if (OUT_REG) begin : g_reg_chk
    // R7: registered output follows the previous combinational result
    a_r7_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (word_out == $past(comb_word)));
  end else begin : g_comb_chk
    // R7: combinational output follows the datapath
    a_r7_comb_follow: assert property (@(posedge clk) disable iff (!rst_n)
      word_out == comb_word);
  end
endmodule

bind sbox_word_unit sbox_word_unit_chk #(.LANES(LANES), .OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inv_sel    (inv_sel),
  .word_in    (word_in),
  .word_out   (word_out),
  .comb_word  (comb_word),
  .inv_in_bus (inv_in_bus),
  .inv_out_bus(inv_out_bus)
);

// File: tb/sbox_word_unit_tb.sv
module sbox_word_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_sel = 1'b0;
  logic [31:0] word_in = '0;
  logic [31:0] word_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] ref_f [256];
  logic [7:0] ref_i [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_word_unit #(.LANES(LANES), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .word_in(word_in), .word_out(word_out)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] m_inverse(input logic [7:0] a);
    for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) return 8'(c);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_aff(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return r;
  endfunction

  function automatic logic [7:0] m_iaff(input logic [7:0] y);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = y[(i+2)%8] ^ y[(i+5)%8] ^ y[(i+7)%8] ^ ((8'h05 >> i) & 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input logic dir, input logic [31:0] w, output logic [31:0] res);
    inv_sel = dir;
    word_in = w;
    @(posedge clk);
    @(negedge clk);
    res = word_out;
  endtask

  function automatic logic [31:0] lanes_of(input logic [7:0] x);
    return {x ^ 8'hc3, ~x, x + 8'h01, x};
  endfunction

  function automatic logic [31:0] exp_word(input logic dir, input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = dir ? ref_i[w[k*8 +: 8]] : ref_f[w[k*8 +: 8]];
    return r;
  endfunction

  task automatic t_reset();
    word_in = 32'hdeadbeef;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset clears output", word_out, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_known();
    logic [31:0] r;
    apply(1'b0, 32'h53_01_00_00, r);
    check("R3 forward 00->63, 01->7c, 53->ed", r, 32'hed_7c_63_63);
    apply(1'b1, 32'h63_63_7c_ed, r);
    check("R3 inverse 63->00", r, 32'h00_00_01_53);
  endtask

  task automatic t_forward_all();
    logic [31:0] r;
    for (int v = 0; v < 256; v++) begin
      apply(1'b0, lanes_of(8'(v)), r);
      check("R2 R5 forward sweep", r, exp_word(1'b0, lanes_of(8'(v))));
    end
  endtask

  task automatic t_inverse_all();
    logic [31:0] r;
    for (int v = 0; v < 256; v++) begin
      apply(1'b1, lanes_of(8'(v)), r);
      check("R4 inverse sweep", r, exp_word(1'b1, lanes_of(8'(v))));
    end
  endtask

  task automatic t_roundtrip();
    logic [31:0] a, b;
    for (int v = 0; v < 256; v++) begin
      apply(1'b0, lanes_of(8'(v)), a);
      apply(1'b1, a, b);
      check("R6 forward then inverse", b, lanes_of(8'(v)));
    end
  endtask

  task automatic t_lane_isolation();
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v += 17) begin
        logic [31:0] w;
        w = 32'h44_33_22_11;
        w[k*8 +: 8] = 8'(v);
        apply(1'b0, w, r);
        check("R1 lane independence", r, exp_word(1'b0, w));
      end
    end
  endtask

  task automatic t_dir_switch();
    logic [31:0] r;
    for (int n = 0; n < 16; n++) begin
      logic d;
      d = n[0];
      apply(d, 32'h9a_3c_f0_07, r);
      check("R8 per-word direction", r, exp_word(d, 32'h9a_3c_f0_07));
    end
  endtask

  initial begin
    for (int v = 0; v < 256; v++) begin
      ref_f[v] = m_aff(m_inverse(8'(v)));
      ref_i[v] = m_inverse(m_iaff(8'(v)));
    end
    @(negedge clk);
    t_reset();
    t_known();
    t_forward_all();
    t_inverse_all();
    t_roundtrip();
    t_lane_isolation();
    t_dir_switch();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule